// File: doc/BRIEF.md
# Multi-Cycle 32-bit Integer Datapath

This block is the storage-and-arithmetic half of a small load/store processor in which every instruction is spread over several clock steps. A single ALU does the PC increment, the branch-target sum, effective-address arithmetic and register arithmetic, each in a different cycle. A single memory port serves both instruction fetch and data access. Every value that has to survive from one step to the next is held in an intermediate register: the instruction register, the memory data register, the two operand latches and the ALU result latch.

The datapath contains no sequencing of its own. An external controller drives a set of per-cycle select and write-enable lines. It reads back the opcode, the function field and the ALU zero flag to choose its next state. Memory sits outside the block. The memory is a word array whose read data follows the address within the same cycle and which takes writes on the clock edge. Its write enable comes straight from the controller. The datapath supplies the address and the store data. Reset is asserted asynchronously and released through a two-stage synchronizer.

Top module: `mc_datapath`

## Requirements
- R1: While reset is held, the PC, the instruction register, all intermediate registers and every register-file entry are zero. As a result, with `mem_sel_data` low, `mem_addr`, `opcode` and `funct` read 0, and `zero` reads 1 under add with ALU A on the PC and ALU B on the B latch.
- R2: `mem_addr` is the PC when `mem_sel_data` is 0 and the ALU result latch when it is 1. `mem_wdata` is the B latch.
- R3: The instruction register loads `mem_rdata` on a clock edge where `ir_wr` is high and holds otherwise. `opcode` is its bits 31..26 and `funct` is its bits 5..0.
- R4: On every clock edge, the A latch and B latch load the register-file entries addressed by instruction bits 25..21 and 20..16. On the same edge, the memory data register loads `mem_rdata` and the ALU result latch loads the ALU output.
- R5: ALU input A is the PC when `alu_a_reg` is 0 and the A latch when it is 1. ALU input B is selected by `alu_b_sel`: 00 the B latch, 01 the constant 4, 10 the sign-extended bits 15..0, 11 that value shifted left by two.
- R6: `alu_op` 00 adds and 01 subtracts. With `alu_op` 10 the function field selects the operation: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed set-less-than. Any other function code, and `alu_op` 11, add. `zero` is high exactly when the ALU output is 0.
- R7: `pc_src` picks the next PC value: 00 the ALU output, 01 the ALU result latch, 10 the PC's top four bits followed by instruction bits 25..0 and two zero bits, 11 the ALU output.
- R8: The PC is written on a clock edge when `pc_wr` is high, or when `pc_wr_cond` is high and `zero` is high. Otherwise the PC holds.
- R9: With `rf_wr` high, the register file writes the entry selected by bits 15..11 (`rf_dst_rd`=1) or bits 20..16 (`rf_dst_rd`=0). The written data is the memory data register (`rf_src_mem`=1) or the ALU result latch (`rf_src_mem`=0). Entry 0 always reads as zero, and writes to it are ignored.
- R10: Driven by a conventional ten-state controller, programs mixing register arithmetic (opcode 0x00), load word (0x23), store word (0x2B), branch-if-equal (0x04, offset in words from the following instruction) and jump (0x02) leave memory exactly as instruction-level semantics predict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_wr | input | 1 | Unconditional PC write |
| pc_wr_cond | input | 1 | PC write qualified by the zero flag |
| pc_src | input | 2 | Next-PC source select |
| ir_wr | input | 1 | Instruction register load enable |
| mem_sel_data | input | 1 | Memory address from the ALU result latch instead of the PC |
| rf_wr | input | 1 | Register file write enable |
| rf_dst_rd | input | 1 | Write destination from bits 15..11 instead of 20..16 |
| rf_src_mem | input | 1 | Write data from the memory data register instead of the ALU latch |
| alu_a_reg | input | 1 | ALU A operand from the A latch instead of the PC |
| alu_b_sel | input | 2 | ALU B operand select |
| alu_op | input | 2 | ALU operation class |
| mem_rdata | input | 32 | Memory read data |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory store data |
| opcode | output | 6 | Instruction bits 31..26 |
| funct | output | 6 | Instruction bits 5..0 |
| zero | output | 1 | ALU output equals zero |

## Verification
A wrong PC shows up at `mem_addr` in the very next fetch cycle. A corrupted instruction register shows on `opcode` and `funct` one cycle after the fetch. Wrong operand latches or a wrong ALU operation show either as a wrong `zero` in the execute or compare cycle, or as a wrong address or store data two cycles after decode. A register-file write error stays hidden until a later store or branch reads that entry, so the test program stores every result it computes and compares the whole data region at the end.

// File: rtl/mcd_pkg.sv
package mcd_pkg;
  localparam int XLEN  = 32;
  localparam int RADDR = 5;

  typedef enum logic [2:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_OR,
    ALU_SLT
  } alu_fn_e;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;
endpackage

// File: rtl/mcd_alu.sv
module mcd_alu
  import mcd_pkg::*;
#(
  parameter int DW = XLEN
) (
  input  logic [1:0]    op_sel,
  input  logic [5:0]    funct,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y,
  output logic          zero
);
  alu_fn_e fn;

  // operation decode
  always_comb begin
    fn = ALU_ADD;
    unique case (op_sel)
      2'b01: fn = ALU_SUB;
      2'b10: begin
        case (funct)
          FN_SUB:  fn = ALU_SUB;
          FN_AND:  fn = ALU_AND;
          FN_OR:   fn = ALU_OR;
          FN_SLT:  fn = ALU_SLT;
          default: fn = ALU_ADD;
        endcase
      end
      default: fn = ALU_ADD;
    endcase
  end

  always_comb begin
    unique case (fn)
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = ($signed(a) < $signed(b)) ? DW'(1) : '0;
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/mcd_regfile.sv
module mcd_regfile
  import mcd_pkg::*;
#(
  parameter int DW = XLEN,
  parameter int AW = RADDR
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] rd1,
  output logic [DW-1:0] rd2
);
  localparam int NREG = 1 << AW;

  logic [DW-1:0] regs_q [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else begin
      for (int i = 1; i < NREG; i++) begin
        if (we && (wa == AW'(i))) regs_q[i] <= wd;
      end
    end
  end

  assign rd1 = (ra1 == '0) ? '0 : regs_q[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs_q[ra2];

  AST_WR_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wa != '0) |=> (ra1 != $past(wa) || rd1 == $past(wd))); // R9
endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import mcd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pc_wr,
  input  logic        pc_wr_cond,
  input  logic [1:0]  pc_src,
  input  logic        ir_wr,
  input  logic        mem_sel_data,
  input  logic        rf_wr,
  input  logic        rf_dst_rd,
  input  logic        rf_src_mem,
  input  logic        alu_a_reg,
  input  logic [1:0]  alu_b_sel,
  input  logic [1:0]  alu_op,
  input  logic [31:0] mem_rdata,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic [5:0]  opcode,
  output logic [5:0]  funct,
  output logic        zero
);
  localparam int DW    = XLEN;
  localparam int AW    = RADDR;
  localparam int IMM_W = 16;
  localparam int JMP_W = 26;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [DW-1:0] pc_q, pc_d;
  logic [DW-1:0] ir_q, ir_d;
  logic [DW-1:0] mdr_q, mdr_d;
  logic [DW-1:0] a_q, a_d;
  logic [DW-1:0] b_q, b_d;
  logic [DW-1:0] alo_q, alo_d;

  logic [DW-1:0] rf_rd1, rf_rd2, rf_wd;
  logic [AW-1:0] rf_wa;
  logic [DW-1:0] alu_a, alu_b, alu_y;
  logic [DW-1:0] imm_sx, imm_sx_sh, jmp_tgt;
  logic          pc_load;

  assign imm_sx    = {{(DW-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
  assign imm_sx_sh = {imm_sx[DW-3:0], 2'b00};
  assign jmp_tgt   = {pc_q[DW-1:DW-4], ir_q[JMP_W-1:0], 2'b00};

  assign rf_wa = rf_dst_rd ? ir_q[15:11] : ir_q[20:16];
  assign rf_wd = rf_src_mem ? mdr_q : alo_q;

  mcd_regfile #(.DW(DW), .AW(AW)) u_rf (
    .clk   (clk),
    .rst_n (rst_int_n),
    .ra1   (ir_q[25:21]),
    .ra2   (ir_q[20:16]),
    .we    (rf_wr),
    .wa    (rf_wa),
    .wd    (rf_wd),
    .rd1   (rf_rd1),
    .rd2   (rf_rd2)
  );

  // operand selection
  always_comb begin
    alu_a = alu_a_reg ? a_q : pc_q;
    unique case (alu_b_sel)
      2'b00:   alu_b = b_q;
      2'b01:   alu_b = DW'(4);
      2'b10:   alu_b = imm_sx;
      default: alu_b = imm_sx_sh;
    endcase
  end

  mcd_alu #(.DW(DW)) u_alu (
    .op_sel (alu_op),
    .funct  (ir_q[5:0]),
    .a      (alu_a),
    .b      (alu_b),
    .y      (alu_y),
    .zero   (zero)
  );

  // next-state
  assign pc_load = pc_wr | (pc_wr_cond & zero);

  always_comb begin
    pc_d = pc_q;
    if (pc_load) begin
      unique case (pc_src)
        2'b01:   pc_d = alo_q;
        2'b10:   pc_d = jmp_tgt;
        default: pc_d = alu_y;
      endcase
    end
    ir_d  = ir_wr ? mem_rdata : ir_q;
    mdr_d = mem_rdata;
    a_d   = rf_rd1;
    b_d   = rf_rd2;
    alo_d = alu_y;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pc_q  <= '0;
      ir_q  <= '0;
      mdr_q <= '0;
      a_q   <= '0;
      b_q   <= '0;
      alo_q <= '0;
    end else begin
      pc_q  <= pc_d;
      ir_q  <= ir_d;
      mdr_q <= mdr_d;
      a_q   <= a_d;
      b_q   <= b_d;
      alo_q <= alo_d;
    end
  end

  assign mem_addr  = mem_sel_data ? alo_q : pc_q;
  assign mem_wdata = b_q;
  assign opcode    = ir_q[31:26];
  assign funct     = ir_q[5:0];

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!pc_wr && !pc_wr_cond) |=> $stable(pc_q)); // R8
  AST_COND_BLOCK: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!pc_wr && pc_wr_cond && !zero) |=> $stable(pc_q)); // R8
  AST_IR_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    !ir_wr |=> $stable(ir_q)); // R3
  AST_FETCH_INC: assert property (@(posedge clk) disable iff (!rst_int_n)
    (pc_wr && pc_src == 2'b00 && !alu_a_reg && alu_b_sel == 2'b01 && alu_op == 2'b00)
      |=> (pc_q == $past(pc_q) + DW'(4))); // R5
endmodule

// File: tb/mc_datapath_test.sv
module mc_datapath_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pc_wr, pc_wr_cond, ir_wr, mem_sel_data, rf_wr, rf_dst_rd, rf_src_mem, alu_a_reg;
  logic [1:0]  pc_src, alu_b_sel, alu_op;
  logic [31:0] mem_rdata, mem_addr, mem_wdata;
  logic [5:0]  opcode, funct;
  logic        zero;
  logic        mem_wr;

  always #(CLK_PERIOD/2) clk = ~clk;

  mc_datapath uut (
    .clk(clk), .rst_n(rst_n), .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .pc_src(pc_src),
    .ir_wr(ir_wr), .mem_sel_data(mem_sel_data), .rf_wr(rf_wr), .rf_dst_rd(rf_dst_rd),
    .rf_src_mem(rf_src_mem), .alu_a_reg(alu_a_reg), .alu_b_sel(alu_b_sel), .alu_op(alu_op),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .opcode(opcode), .funct(funct), .zero(zero)
  );

  // memory model: combinational read, write on the edge
  logic [31:0] mem     [0:255];
  logic [31:0] ref_mem [0:255];
  logic [31:0] regs    [0:31];
  logic [31:0] ref_pc;

  assign mem_rdata = mem[mem_addr[9:2]];
  always @(posedge clk) if (mem_wr) mem[mem_addr[9:2]] <= mem_wdata;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction
  function automatic logic [31:0] enc_j(int word_addr);
    return {6'h02, 26'(word_addr)};
  endfunction
  function automatic logic [31:0] sx(logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction
  function automatic logic [31:0] ref_alu(logic [5:0] fn, logic [31:0] a, logic [31:0] b);
    case (fn)
      6'h22:   return a - b;
      6'h24:   return a & b;
      6'h25:   return a | b;
      6'h2A:   return (signed'(a) < signed'(b)) ? 32'd1 : 32'd0;
      default: return a + b;
    endcase
  endfunction

  // controller drive per state
  task automatic drive(int st);
    pc_wr = 0; pc_wr_cond = 0; pc_src = 2'b00; ir_wr = 0; mem_sel_data = 0; mem_wr = 0;
    rf_wr = 0; rf_dst_rd = 0; rf_src_mem = 0; alu_a_reg = 0; alu_b_sel = 2'b00; alu_op = 2'b00;
    case (st)
      0: begin ir_wr = 1; alu_b_sel = 2'b01; pc_wr = 1; end
      1: alu_b_sel = 2'b11;
      2: begin alu_a_reg = 1; alu_b_sel = 2'b10; end
      3: mem_sel_data = 1;
      4: begin rf_wr = 1; rf_src_mem = 1; end
      5: begin mem_sel_data = 1; mem_wr = 1; end
      6: begin alu_a_reg = 1; alu_op = 2'b10; end
      7: begin rf_wr = 1; rf_dst_rd = 1; end
      8: begin alu_a_reg = 1; alu_op = 2'b01; pc_wr_cond = 1; pc_src = 2'b01; end
      9: begin pc_wr = 1; pc_src = 2'b10; end
      default: ;
    endcase
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    finish_run();
  end

  initial begin
    logic [31:0] ins, ea, res;
    logic [5:0]  dec_op;
    int st, nxt, icount;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    for (int i = 0; i < 32; i++) regs[i] = '0;
    // program
    mem[0]  = enc_i(6'h23, 0, 1, 32'h100);
    mem[1]  = enc_i(6'h23, 0, 2, 32'h104);
    mem[2]  = enc_r(1, 2, 3, 6'h20);
    mem[3]  = enc_r(1, 2, 4, 6'h22);
    mem[4]  = enc_r(1, 2, 5, 6'h24);
    mem[5]  = enc_r(1, 2, 6, 6'h25);
    mem[6]  = enc_r(2, 1, 7, 6'h2A);
    mem[7]  = enc_r(1, 2, 8, 6'h2A);
    mem[8]  = enc_r(1, 1, 0, 6'h20);   // write to entry 0 (R9)
    mem[9]  = enc_i(6'h2B, 0, 0, 32'h140);
    mem[10] = enc_i(6'h2B, 0, 3, 32'h144);
    mem[11] = enc_i(6'h2B, 0, 4, 32'h148);
    mem[12] = enc_i(6'h2B, 0, 5, 32'h14C);
    mem[13] = enc_i(6'h2B, 0, 6, 32'h150);
    mem[14] = enc_i(6'h2B, 0, 7, 32'h154);
    mem[15] = enc_i(6'h2B, 0, 8, 32'h158);
    mem[16] = enc_i(6'h04, 1, 2, 5);   // not taken
    mem[17] = enc_i(6'h04, 7, 7, 2);   // taken, skips two
    mem[18] = enc_i(6'h2B, 0, 1, 32'h15C);
    mem[19] = enc_i(6'h2B, 0, 1, 32'h15C);
    mem[20] = enc_i(6'h23, 0, 9, 32'h108);
    mem[21] = enc_i(6'h2B, 9, 2, -4);  // negative offset
    mem[22] = enc_r(1, 2, 10, 6'h27);  // unlisted function code adds
    mem[23] = enc_i(6'h2B, 0, 10, 32'h168);
    mem[24] = enc_j(32);
    mem[32] = enc_j(32);
    mem[64] = 32'd7;
    mem[65] = 32'hFFFF_FFFD;
    mem[66] = 32'h164;
    for (int i = 0; i < 256; i++) ref_mem[i] = mem[i];
    ref_pc = '0;

    rst_n = 0;
    drive(-1);
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset mem_addr", mem_addr, 32'h0);
    chk("R1 reset opcode", 32'(opcode), 32'h0);
    chk("R1 reset funct", 32'(funct), 32'h0);
    chk("R1 reset zero", 32'(zero), 32'h1);
    rst_n = 1;
    repeat (3) @(negedge clk);

    st = 0; icount = 0; ins = '0; ea = '0; res = '0; dec_op = '0;
    while (icount < 40) begin
      @(negedge clk);
      drive(st);
      #1;
      nxt = 0;
      case (st)
        0: begin  // fetch address exposes the PC: R5, R7, R8
          ins = ref_mem[ref_pc[9:2]];
          chk("R8 fetch address", mem_addr, ref_pc);
          nxt = 1;
        end
        1: begin
          ref_pc = ref_pc + 4;
          chk("R3 opcode", 32'(opcode), 32'(ins[31:26]));
          chk("R3 funct", 32'(funct), 32'(ins[5:0]));
          chk("R2 address from PC", mem_addr, ref_pc);
          dec_op = opcode;
          case (dec_op)
            6'h23, 6'h2B: nxt = 2;
            6'h00:        nxt = 6;
            6'h04:        nxt = 8;
            6'h02:        nxt = 9;
            default:      nxt = 0;
          endcase
        end
        2: begin
          ea = regs[ins[25:21]] + sx(ins[15:0]);
          nxt = (dec_op == 6'h23) ? 3 : 5;
        end
        3: begin
          chk("R4 load address", mem_addr, ea);
          nxt = 4;
        end
        4: begin
          if (ins[20:16] != 0) regs[ins[20:16]] = ref_mem[ea[9:2]];
          icount++;
        end
        5: begin
          chk("R2 store address", mem_addr, ea);
          chk("R4 store data", mem_wdata, regs[ins[20:16]]);
          ref_mem[ea[9:2]] = regs[ins[20:16]];
          icount++;
        end
        6: begin
          res = ref_alu(ins[5:0], regs[ins[25:21]], regs[ins[20:16]]);
          chk("R6 zero flag", 32'(zero), 32'(res == 0));
          nxt = 7;
        end
        7: begin
          if (ins[15:11] != 0) regs[ins[15:11]] = res;
          icount++;
        end
        8: begin
          chk("R6 compare zero", 32'(zero), 32'(regs[ins[25:21]] == regs[ins[20:16]]));
          if (regs[ins[25:21]] == regs[ins[20:16]])
            ref_pc = ref_pc + {sx(ins[15:0])[29:0], 2'b00};
          icount++;
        end
        9: begin
          ref_pc = {ref_pc[31:28], ins[25:0], 2'b00};  // R7
          icount++;
        end
        default: ;
      endcase
      st = nxt;
    end
    @(negedge clk);
    drive(-1);
    // R10 and R9: data region after the program
    for (int i = 64; i < 96; i++) chk("R10 memory word", mem[i], ref_mem[i]);
    chk("R9 entry 0 stored as zero", mem[80], 32'h0);
    finish_run();
  end
endmodule